// File: doc/BRIEF.md
# Tag-Snooping Reservation Station Pool

This block is a small pool of reservation stations that sits in front of one execution unit, for example a group of floating-point adders. Each station holds an operation, two operand slots and one producer tag per slot. An issuing front end writes a free station with either an operand value or the tag of the station that will produce that value. Every station watches a shared result broadcast bus. When the bus tag matches a pending producer tag, the station copies the data and sets that tag to zero. A zero tag is the only sign that an operand is present; there is no separate ready bit.

A station whose two tags are both zero is offered to a built-in execution stub. When several stations are ready in the same cycle, the oldest one goes first. The stub works with a fixed latency and performs one of four simple operations. It then presents the result, tagged with the station's own tag, on a valid/ready result port, and the surrounding chip drives that port onto the broadcast bus. The station stays busy until its result is accepted, and is free for reuse in the next cycle.

Issue is a valid/ready handshake. `iss_ready` is high only while some station is free. The front end must hold its request stable until it is accepted. Results follow the same rule in the other direction: while `res_valid` is high and `res_ready` is low, the result stays unchanged and the next one waits behind it. The broadcast bus input has no back-pressure.

Top module: `rs_pool`

## Requirements
- R1: After reset every station is free: `iss_ready` is 1, `iss_tag` equals BASE_TAG and `res_valid` is 0.
- R2: An issue is accepted only when `iss_valid` and `iss_ready` are both high. `iss_ready` is low while all N stations are busy. `iss_tag` names the lowest-index free station, as BASE_TAG plus its index.
- R3: A station is offered for execution only when both of its producer tags are zero. A station still waiting for an operand produces no result.
- R4: On each cycle with `cdb_valid` high, every busy station compares each non-zero pending tag with `cdb_tag`. On a match it stores `cdb_data` in that slot and clears the tag. A bus word whose tag matches no pending tag, or whose tag is 0, changes nothing.
- R5: When a broadcast in the issue cycle carries the tag that the issued operand waits for, the station captures the bus data at once and does not wait.
- R6: When several stations are ready at once, the one issued earliest is executed first, whatever its index.
- R7: Operation encoding: 0 gives a+b, 1 gives a−b, 2 gives a XOR b and 3 passes a, all modulo 2^DATA_W. `res_valid` rises LAT cycles after the issue edge of a station whose operands are already present. `res_tag` is the station's tag.
- R8: A station stays busy while its result is pending and becomes free in the cycle after the result handshake. While `res_valid` is high and `res_ready` is low, `res_tag` and `res_data` hold their values.
- R9: Station tags run from BASE_TAG to BASE_TAG+N−1 and never use 0, which means "no producer".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_ready | output | 1 | A station is free |
| iss_op | input | 2 | Operation code (see R7) |
| iss_qa | input | TAG_W | Producer tag of operand a, 0 if value given |
| iss_va | input | DATA_W | Value of operand a |
| iss_qb | input | TAG_W | Producer tag of operand b, 0 if value given |
| iss_vb | input | DATA_W | Value of operand b |
| iss_tag | output | TAG_W | Tag of the station an accepted issue takes |
| cdb_valid | input | 1 | Broadcast bus word present |
| cdb_tag | input | TAG_W | Tag of the producing station |
| cdb_data | input | DATA_W | Broadcast value |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Result accepted |
| res_tag | output | TAG_W | Tag of the station that produced the result |
| res_data | output | DATA_W | Result value |

## Verification
The assertions check on every cycle that a result held under back-pressure does not change, that an accepted issue marks its station busy, that a presented result belongs to a busy station, and that the station is freed after the handshake and its tag is in range. Only the bench scenarios can show the rest: that data is captured only on a matching non-zero tag, that a broadcast in the issue cycle is forwarded, that the oldest ready station wins over a lower index, that the latency is exactly LAT, and that each operation gives the correct value.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_SUB  = 2'd1,
    OP_XOR  = 2'd2,
    OP_PASS = 2'd3
  } rs_op_e;
endpackage

// File: rtl/rs_entry.sv
module rs_entry
  import rs_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int TAG_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  rs_op_e            in_op,
  input  logic [TAG_W-1:0]  in_qa,
  input  logic [DATA_W-1:0] in_va,
  input  logic [TAG_W-1:0]  in_qb,
  input  logic [DATA_W-1:0] in_vb,
  input  logic              bus_valid,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              launch,
  input  logic              release_i,
  output logic              busy,
  output logic              ready,
  output rs_op_e            op,
  output logic [DATA_W-1:0] va,
  output logic [DATA_W-1:0] vb
);
  logic [TAG_W-1:0] qa, qb;
  logic             launched;
  logic             fwd_a, fwd_b, snoop_a, snoop_b;

  // forwarding of a broadcast that coincides with the write
  assign fwd_a   = bus_valid && (in_qa != '0) && (bus_tag == in_qa);
  assign fwd_b   = bus_valid && (in_qb != '0) && (bus_tag == in_qb);
  // capture while resident
  assign snoop_a = busy && bus_valid && (qa != '0) && (bus_tag == qa);
  assign snoop_b = busy && bus_valid && (qb != '0) && (bus_tag == qb);

  assign ready = busy && !launched && (qa == '0) && (qb == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      launched <= 1'b0;
      op       <= OP_ADD;
      qa       <= '0;
      qb       <= '0;
      va       <= '0;
      vb       <= '0;
    end else if (alloc) begin
      busy     <= 1'b1;
      launched <= 1'b0;
      op       <= in_op;
      qa       <= fwd_a ? '0 : in_qa;
      va       <= fwd_a ? bus_data : in_va;
      qb       <= fwd_b ? '0 : in_qb;
      vb       <= fwd_b ? bus_data : in_vb;
    end else begin
      if (release_i) busy <= 1'b0;
      if (launch) launched <= 1'b1;
      if (snoop_a) begin
        qa <= '0;
        va <= bus_data;
      end
      if (snoop_b) begin
        qb <= '0;
        vb <= bus_data;
      end
    end
  end
endmodule

// File: rtl/rs_age_pick.sv
module rs_age_pick #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] alloc_vec,
  input  logic [N-1:0] ready_vec,
  output logic [N-1:0] grant,
  output logic         any
);
  // older[i][j] set: station i was written before station j
  logic [N-1:0] older [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) older[i] <= '0;
    end else begin
      for (int k = 0; k < N; k++) begin
        if (alloc_vec[k]) begin
          for (int j = 0; j < N; j++) begin
            older[k][j] <= 1'b0;
            if (j != k) older[j][k] <= 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      grant[i] = ready_vec[i];
      for (int j = 0; j < N; j++) begin
        if (j != i && ready_vec[j] && older[j][i]) grant[i] = 1'b0;
      end
    end
    any = |ready_vec;
  end
endmodule

// File: rtl/rs_exec_stub.sv
module rs_exec_stub
  import rs_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int TAG_W  = 4,
  parameter int N      = 4,
  parameter int LAT    = 3,
  parameter int BASE_TAG = 1,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1,
  localparam int CNT_W = $clog2(LAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  start_idx,
  input  rs_op_e            op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic              accept,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [TAG_W-1:0]  res_tag,
  output logic [DATA_W-1:0] res_data,
  output logic              done,
  output logic [IDX_W-1:0]  done_idx
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx_q;
  logic [DATA_W-1:0] calc;

  always_comb begin
    unique case (op)
      OP_ADD:  calc = a + b;
      OP_SUB:  calc = a - b;
      OP_XOR:  calc = a ^ b;
      default: calc = a;
    endcase
  end

  assign res_valid = busy_q && (cnt == '0);
  assign done      = res_valid && res_ready;
  assign accept    = !busy_q || done;
  assign done_idx  = idx_q;
  assign res_tag   = TAG_W'(BASE_TAG) + TAG_W'(idx_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      cnt      <= '0;
      idx_q    <= '0;
      res_data <= '0;
    end else if (start) begin
      busy_q   <= 1'b1;
      cnt      <= CNT_W'(LAT - 1);
      idx_q    <= start_idx;
      res_data <= calc;
    end else if (done) begin
      busy_q <= 1'b0;
    end else if (busy_q && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/rs_pool.sv
module rs_pool
  import rs_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int TAG_W    = 4,
  parameter int N        = 4,
  parameter int LAT      = 3,
  parameter int BASE_TAG = 1,
  localparam int IDX_W   = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  output logic              iss_ready,
  input  logic [1:0]        iss_op,
  input  logic [TAG_W-1:0]  iss_qa,
  input  logic [DATA_W-1:0] iss_va,
  input  logic [TAG_W-1:0]  iss_qb,
  input  logic [DATA_W-1:0] iss_vb,
  output logic [TAG_W-1:0]  iss_tag,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [TAG_W-1:0]  res_tag,
  output logic [DATA_W-1:0] res_data
);
  logic [N-1:0]      ent_busy, ent_rdy, alloc_vec, grant, launch_vec, rel_vec;
  rs_op_e            ent_op [N];
  logic [DATA_W-1:0] ent_va [N];
  logic [DATA_W-1:0] ent_vb [N];
  logic [IDX_W-1:0]  free_idx, disp_idx, done_idx;
  logic              free_any, grant_any, ex_accept, disp_go, ex_done;
  rs_op_e            disp_op;
  logic [DATA_W-1:0] disp_a, disp_b;

  // lowest-index free station
  always_comb begin
    free_idx = '0;
    free_any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!ent_busy[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign iss_ready = free_any;
  assign iss_tag   = TAG_W'(BASE_TAG) + TAG_W'(free_idx);

  always_comb begin
    alloc_vec = '0;
    if (iss_valid && iss_ready) alloc_vec[free_idx] = 1'b1;
  end

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_ent
      rs_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_ent (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc     (alloc_vec[g]),
        .in_op     (rs_op_e'(iss_op)),
        .in_qa     (iss_qa),
        .in_va     (iss_va),
        .in_qb     (iss_qb),
        .in_vb     (iss_vb),
        .bus_valid (cdb_valid),
        .bus_tag   (cdb_tag),
        .bus_data  (cdb_data),
        .launch    (launch_vec[g]),
        .release_i (rel_vec[g]),
        .busy      (ent_busy[g]),
        .ready     (ent_rdy[g]),
        .op        (ent_op[g]),
        .va        (ent_va[g]),
        .vb        (ent_vb[g])
      );
    end
  endgenerate

  rs_age_pick #(.N(N)) u_pick (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_vec (alloc_vec),
    .ready_vec (ent_rdy),
    .grant     (grant),
    .any       (grant_any)
  );

  // selected station fields
  always_comb begin
    disp_idx = '0;
    disp_op  = OP_ADD;
    disp_a   = '0;
    disp_b   = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) begin
        disp_idx = IDX_W'(i);
        disp_op  = ent_op[i];
        disp_a   = ent_va[i];
        disp_b   = ent_vb[i];
      end
    end
  end

  assign disp_go    = grant_any && ex_accept;
  assign launch_vec = disp_go ? grant : '0;

  always_comb begin
    rel_vec = '0;
    if (ex_done) rel_vec[done_idx] = 1'b1;
  end

  rs_exec_stub #(
    .DATA_W(DATA_W), .TAG_W(TAG_W), .N(N), .LAT(LAT), .BASE_TAG(BASE_TAG)
  ) u_exec (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (disp_go),
    .start_idx (disp_idx),
    .op        (disp_op),
    .a         (disp_a),
    .b         (disp_b),
    .accept    (ex_accept),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .res_tag   (res_tag),
    .res_data  (res_data),
    .done      (ex_done),
    .done_idx  (done_idx)
  );
endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk #(
  parameter int DATA_W   = 64,
  parameter int TAG_W    = 4,
  parameter int N        = 4,
  parameter int BASE_TAG = 1,
  localparam int IDX_W   = (N > 1) ? $clog2(N) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              iss_valid,
  input logic              iss_ready,
  input logic [TAG_W-1:0]  iss_tag,
  input logic              res_valid,
  input logic              res_ready,
  input logic [TAG_W-1:0]  res_tag,
  input logic [DATA_W-1:0] res_data,
  input logic [N-1:0]      ent_busy
);
  logic [IDX_W-1:0] iss_idx, res_idx;
  assign iss_idx = IDX_W'(iss_tag - TAG_W'(BASE_TAG));
  assign res_idx = IDX_W'(res_tag - TAG_W'(BASE_TAG));

  // R8
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_tag));

  // R2
  alloc_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_ready |=> ent_busy[$past(iss_idx)]);

  // R8
  wb_owner_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ent_busy[res_idx]);

  // R8
  free_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ready |=> !ent_busy[$past(res_idx)]);

  // R9
  tag_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_tag != '0) && (int'(res_tag) >= BASE_TAG) && (int'(res_tag) < BASE_TAG + N));
endmodule

bind rs_pool rs_pool_chk #(
  .DATA_W(DATA_W), .TAG_W(TAG_W), .N(N), .BASE_TAG(BASE_TAG)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .iss_valid (iss_valid),
  .iss_ready (iss_ready),
  .iss_tag   (iss_tag),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_tag   (res_tag),
  .res_data  (res_data),
  .ent_busy  (ent_busy)
);

// File: tb/sim_rs_pool.sv
module sim_rs_pool;
  localparam int DW = 64;
  localparam int TW = 4;
  localparam int LATENCY = 3;
  localparam int NV = 6;

  // stimulus / expected table: op, tag a, val a, tag b, val b, expected
  localparam logic [1:0]    T_OP [NV] = '{2'd0, 2'd1, 2'd2, 2'd0, 2'd3, 2'd1};
  localparam logic [TW-1:0] T_QA [NV] = '{4'd0, 4'd9, 4'd0, 4'd11, 4'd13, 4'd0};
  localparam logic [DW-1:0] T_VA [NV] = '{64'd5, 64'd100, 64'hFF00, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1234, 64'd0};
  localparam logic [TW-1:0] T_QB [NV] = '{4'd0, 4'd0, 4'd10, 4'd12, 4'd0, 4'd9};
  localparam logic [DW-1:0] T_VB [NV] = '{64'd7, 64'd30, 64'h0F0F, 64'd2, 64'd0, 64'd1};
  localparam logic [DW-1:0] T_EX [NV] = '{64'd12, 64'd70, 64'hF00F, 64'd1, 64'd1234, 64'hFFFF_FFFF_FFFF_FFFF};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iss_valid = 1'b0;
  logic iss_ready;
  logic [1:0] iss_op = '0;
  logic [TW-1:0] iss_qa = '0, iss_qb = '0, iss_tag;
  logic [DW-1:0] iss_va = '0, iss_vb = '0;
  logic cdb_valid = 1'b0;
  logic [TW-1:0] cdb_tag = '0;
  logic [DW-1:0] cdb_data = '0;
  logic res_valid;
  logic res_ready = 1'b1;
  logic rr_idle = 1'b1;
  logic [TW-1:0] res_tag;
  logic [DW-1:0] res_data;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rs_pool #(.DATA_W(DW), .TAG_W(TW), .N(4), .LAT(LATENCY), .BASE_TAG(1)) u0 (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op),
    .iss_qa(iss_qa), .iss_va(iss_va), .iss_qb(iss_qb), .iss_vb(iss_vb),
    .iss_tag(iss_tag),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_tag(res_tag), .res_data(res_data)
  );

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_issue(input logic [1:0] op, input logic [TW-1:0] qa, input logic [DW-1:0] va,
                          input logic [TW-1:0] qb, input logic [DW-1:0] vb, output logic [TW-1:0] tg);
    iss_op = op; iss_qa = qa; iss_va = va; iss_qb = qb; iss_vb = vb;
    iss_valid = 1'b1;
    while (!iss_ready) @(negedge clk);
    tg = iss_tag;
    @(negedge clk);
    iss_valid = 1'b0;
  endtask

  task automatic bcast(input logic [TW-1:0] tg, input logic [DW-1:0] d);
    cdb_valid = 1'b1; cdb_tag = tg; cdb_data = d;
    @(negedge clk);
    cdb_valid = 1'b0;
  endtask

  task automatic wait_res(input logic [TW-1:0] etag, input logic [DW-1:0] edata, input string req);
    for (int n = 0; n < 60; n++) begin
      if (res_valid) begin
        check(res_tag == etag, {req, " tag"}, DW'(res_tag), DW'(etag));
        check(res_data == edata, {req, " data"}, res_data, edata);
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = rr_idle;
        return;
      end
      @(negedge clk);
    end
    check(1'b0, {req, " no result"}, 64'd0, edata);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [TW-1:0] tg;
    int lat_cnt;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(iss_ready == 1'b1, "R1 ready", DW'(iss_ready), 64'd1);
    check(iss_tag == 4'd1, "R1 tag", DW'(iss_tag), 64'd1);
    check(res_valid == 1'b0, "R1 res_valid", DW'(res_valid), 64'd0);

    // table: R7 operations, R4 capture, R3 wait for operands
    for (int v = 0; v < NV; v++) begin
      do_issue(T_OP[v], T_QA[v], (T_QA[v] != 0) ? 64'hDEAD : T_VA[v],
               T_QB[v], (T_QB[v] != 0) ? 64'hBEEF : T_VB[v], tg);
      check(tg == 4'd1, "R2 lowest free", DW'(tg), 64'd1);
      if (T_QA[v] != 0) bcast(T_QA[v], T_VA[v]);
      if (T_QB[v] != 0) bcast(T_QB[v], T_VB[v]);
      wait_res(4'd1, T_EX[v], "R7 table");
    end

    // R7 latency
    do_issue(2'd0, 4'd0, 64'd3, 4'd0, 64'd4, tg);
    lat_cnt = 1;
    while (!res_valid && lat_cnt < 40) begin
      @(negedge clk);
      if (!res_valid) lat_cnt++;
    end
    check(lat_cnt == LATENCY, "R7 latency", DW'(lat_cnt), DW'(LATENCY));
    wait_res(4'd1, 64'd7, "R7 latency");

    // R2 full pool, R3 waiting stations produce nothing
    for (int i = 0; i < 4; i++) begin
      do_issue(2'd0, TW'(9 + i), 64'd0, 4'd0, 64'd0, tg);
      check(tg == TW'(i + 1), "R2 alloc order", DW'(tg), DW'(i + 1));
    end
    check(iss_ready == 1'b0, "R2 full", DW'(iss_ready), 64'd0);
    // R4 non-matching and zero tags ignored
    bcast(4'd14, 64'd555);
    bcast(4'd0, 64'd666);
    repeat (LATENCY + 3) @(negedge clk);
    check(res_valid == 1'b0, "R4 ignore R3", DW'(res_valid), 64'd0);
    check(iss_ready == 1'b0, "R4 still full", DW'(iss_ready), 64'd0);
    bcast(4'd11, 64'd77);
    wait_res(4'd3, 64'd77, "R4 match");
    // R8 freed after handshake
    check(iss_ready == 1'b1, "R8 freed", DW'(iss_ready), 64'd1);
    check(iss_tag == 4'd3, "R8 freed tag", DW'(iss_tag), 64'd3);
    bcast(4'd9, 64'd21);
    wait_res(4'd1, 64'd21, "R4 drain");
    bcast(4'd10, 64'd22);
    wait_res(4'd2, 64'd22, "R4 drain");
    bcast(4'd12, 64'd24);
    wait_res(4'd4, 64'd24, "R4 drain");

    // R4 zero-tag broadcast leaves a present value alone
    do_issue(2'd0, 4'd0, 64'd5, 4'd9, 64'd0, tg);
    bcast(4'd0, 64'd999);
    bcast(4'd9, 64'd3);
    wait_res(4'd1, 64'd8, "R4 zero tag");

    // R5 same-cycle forward
    iss_op = 2'd0; iss_qa = 4'd9; iss_va = 64'd0; iss_qb = 4'd0; iss_vb = 64'd2;
    iss_valid = 1'b1;
    cdb_valid = 1'b1; cdb_tag = 4'd9; cdb_data = 64'd40;
    @(negedge clk);
    iss_valid = 1'b0;
    cdb_valid = 1'b0;
    wait_res(4'd1, 64'd42, "R5 forward");

    // R6 oldest first under back-pressure
    rr_idle = 1'b0;
    res_ready = 1'b0;
    do_issue(2'd0, 4'd0, 64'd1, 4'd0, 64'd1, tg);
    do_issue(2'd0, 4'd0, 64'd10, 4'd0, 64'd10, tg);
    do_issue(2'd0, 4'd11, 64'd0, 4'd0, 64'd3, tg);
    check(tg == 4'd3, "R6 setup", DW'(tg), 64'd3);
    wait_res(4'd1, 64'd2, "R6 first");
    do_issue(2'd0, 4'd0, 64'd100, 4'd0, 64'd1, tg);
    check(tg == 4'd1, "R6 reuse slot", DW'(tg), 64'd1);
    bcast(4'd11, 64'd4);
    repeat (LATENCY + 2) @(negedge clk);
    wait_res(4'd2, 64'd20, "R8 held");
    wait_res(4'd3, 64'd7, "R6 oldest");
    rr_idle = 1'b1;
    wait_res(4'd1, 64'd101, "R6 younger");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule